// File: doc/BRIEF.md
# Move Elimination Decision Unit

At rename, this unit decides for each move candidate whether the move can be eliminated. An eliminated move shares the source's physical register and needs no new one. Up to `LANES` candidates arrive per cycle in program order. Each candidate is granted only if all of these hold:

- its source and destination are owned by the same register file;
- that file's per-cycle elimination quota is not used up;
- the file's zero-only mode, if enabled, is satisfied;
- a destination nested in a wider parent register meets the full-width-write rule.

A later lane counts the grants of earlier lanes in the same file. The counts start again from zero every cycle.

The unit also keeps a known-zero bit for every architectural register. A write port sets these bits for zero idioms and clears them for ordinary writes. The bit of the source register tells whether a granted move is a zero move. For each granted move the unit picks the register that the destination should alias. It suppresses the alias update when that register is the destination itself. The mapping storage and the allocation counters sit outside the unit. The outside logic supplies the source's rename parent and that parent's current alias as inputs.

Top module: `mvelim_unit`

## Requirements
- R1: A candidate whose source file index differs from its destination file index is never granted.
- R2: A file whose quota field is 0 grants any number of same-file candidates in a cycle. The per-file grant count starts from zero in every cycle.
- R3: With a non-zero quota Q for a file, at most Q candidates of that file are granted in one cycle. Lanes are taken in order from index 0 upward, and a candidate is refused once the earlier lanes of its file hold Q grants.
- R4: When a file's zero-only bit is 1, a candidate in that file is granted only if the known-zero bit of its source is 1.
- R5: When the destination is flagged as nested in a parent, a grant needs both the parent-permits flag and the clears-upper flag.
- R6: A write with the zero flag set sets the known-zero bits of the written register and of its sub-register mask. It also sets the bits of its parent mask, but only when clears-upper is 1. The bits are visible from the next cycle.
- R7: A write with the zero flag clear and the eliminated flag clear clears the same set of bits. A write with the zero flag clear and the eliminated flag set leaves the vector unchanged.
- R8: The zero-move output of a lane is 1 exactly when the lane is granted and its source's known-zero bit is 1.
- R9: The alias target is the source's root register when the root is valid, and the source itself otherwise. It is replaced by the root's recorded alias when that alias is valid. The alias write strobe is 1 for a granted lane whose target differs from its destination.
- R10: Reset clears every known-zero bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_quota | input | NUM_FILES*QUOTA_W | Per-file elimination quota per cycle, 0 = unlimited |
| cfg_zero_only | input | NUM_FILES | Per-file zero-only mode |
| mv_valid | input | LANES | Candidate present in lane |
| mv_src | input | LANES*AREG_W | Source architectural register |
| mv_dst | input | LANES*AREG_W | Destination architectural register |
| mv_src_file | input | LANES*FILE_W | File owning the source |
| mv_dst_file | input | LANES*FILE_W | File owning the destination |
| mv_dst_nested | input | LANES | Destination renamed as part of a wider parent |
| mv_parent_ok | input | LANES | Parent register permits move elimination |
| mv_clears_upper | input | LANES | Write clears the parent's upper bits |
| mv_src_has_root | input | LANES | Source has a rename root register |
| mv_src_root | input | LANES*AREG_W | Rename root of the source |
| mv_root_alias_vld | input | LANES | Root currently carries an alias |
| mv_root_alias | input | LANES*AREG_W | Current alias of the root |
| wr_valid | input | 1 | Register write update present |
| wr_reg | input | AREG_W | Register written |
| wr_sub_mask | input | NUM_AREGS | Sub-registers of the written register |
| wr_parent_mask | input | NUM_AREGS | Parent registers of the written register |
| wr_clears_upper | input | 1 | Write clears parents' upper bits |
| wr_zero | input | 1 | Write is a zero idiom |
| wr_elim | input | 1 | Write came from an eliminated move |
| mv_grant | output | LANES | Elimination granted |
| mv_zero | output | LANES | Granted move of a known-zero value |
| alias_we | output | LANES | Alias table write strobe |
| alias_dst | output | LANES*AREG_W | Alias entry to write |
| alias_tgt | output | LANES*AREG_W | Register to alias to |
| zero_vec | output | NUM_AREGS | Known-zero vector |

## Verification
Several properties are checked on every cycle. A grant never crosses files and never breaks the zero-only or nested-destination rules. No file's grants in a cycle exceed its non-zero quota, and zero-move and alias strobes appear only on granted lanes. Each kind of write leaves the known-zero vector in its required state on the next cycle. The bench scenarios are needed to show the things a property cannot: that legal candidates are in fact granted, that quota counting starts fresh every cycle and follows lane order, that parent bits depend on clears-upper, and how the alias target is chosen.

// File: rtl/mvelim_pkg.sv
package mvelim_pkg;

   // Reason a lane was refused; kept for observation inside the gate
   typedef enum logic [2:0] {
      RSN_GRANT  = 3'd0,
      RSN_IDLE   = 3'd1,
      RSN_FILE   = 3'd2,
      RSN_SHAPE  = 3'd3,
      RSN_QUOTA  = 3'd4,
      RSN_ZONLY  = 3'd5
   } refuse_rsn_e;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/mvelim_zero_track.sv
module mvelim_zero_track #(
   parameter int NUM_AREGS = 32,
   parameter int AREG_W    = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_valid,
   input  logic [AREG_W-1:0]    wr_reg,
   input  logic [NUM_AREGS-1:0] wr_sub_mask,
   input  logic [NUM_AREGS-1:0] wr_parent_mask,
   input  logic                 wr_clears_upper,
   input  logic                 wr_zero,
   input  logic                 wr_elim,
   output logic [NUM_AREGS-1:0] zero_q
);

   logic [NUM_AREGS-1:0] self_bit;
   logic [NUM_AREGS-1:0] touch;
   logic [NUM_AREGS-1:0] zero_d;

   always_comb begin
      for (int k = 0; k < NUM_AREGS; k++)
         self_bit[k] = (wr_reg == AREG_W'(k));
      touch = self_bit | wr_sub_mask | (wr_clears_upper ? wr_parent_mask : '0);
   end

   always_comb begin
      zero_d = zero_q;
      if (wr_valid) begin
         if (wr_zero)
            zero_d = zero_q | touch;
         else if (!wr_elim)
            zero_d = zero_q & ~touch;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) zero_q <= '0;
      else        zero_q <= zero_d;
   end

   // R6
   zset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && wr_zero |=> zero_q[$past(wr_reg)]);
   // R7
   zclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_zero && !wr_elim |=> !zero_q[$past(wr_reg)]);
   // R7
   zkeep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_valid || (!wr_zero && wr_elim)) |=> zero_q == $past(zero_q));

endmodule

// File: rtl/mvelim_lane_gate.sv
module mvelim_lane_gate
   import mvelim_pkg::*;
#(
   parameter int FILE_W  = 2,
   parameter int QUOTA_W = 3,
   parameter int CNT_W   = 2
) (
   input  logic               valid,
   input  logic [FILE_W-1:0]  src_file,
   input  logic [FILE_W-1:0]  dst_file,
   input  logic               dst_nested,
   input  logic               parent_ok,
   input  logic               clears_upper,
   input  logic [QUOTA_W-1:0] quota,
   input  logic               zero_only,
   input  logic               src_zero,
   input  logic [CNT_W-1:0]   used,
   output logic               grant,
   output refuse_rsn_e        rsn
);

   localparam int CMP_W = max_int(CNT_W, QUOTA_W);

   logic [CMP_W-1:0] used_x;
   logic [CMP_W-1:0] quota_x;
   logic             quota_full;

   assign used_x     = CMP_W'(used);
   assign quota_x    = CMP_W'(quota);
   assign quota_full = (quota_x != '0) && (used_x >= quota_x);

   always_comb begin
      if (!valid)                                     rsn = RSN_IDLE;
      else if (src_file != dst_file)                  rsn = RSN_FILE;
      else if (dst_nested && !(parent_ok && clears_upper)) rsn = RSN_SHAPE;
      else if (quota_full)                            rsn = RSN_QUOTA;
      else if (zero_only && !src_zero)                rsn = RSN_ZONLY;
      else                                            rsn = RSN_GRANT;
   end

   assign grant = (rsn == RSN_GRANT);

endmodule

// File: rtl/mvelim_alias_pick.sv
module mvelim_alias_pick #(
   parameter int AREG_W = 5
) (
   input  logic              grant,
   input  logic [AREG_W-1:0] src,
   input  logic [AREG_W-1:0] dst,
   input  logic              has_root,
   input  logic [AREG_W-1:0] root,
   input  logic              root_alias_vld,
   input  logic [AREG_W-1:0] root_alias,
   output logic              we,
   output logic [AREG_W-1:0] tgt
);

   logic [AREG_W-1:0] base;

   assign base = has_root ? root : src;
   assign tgt  = root_alias_vld ? root_alias : base;
   assign we   = grant && (tgt != dst);

endmodule

// File: rtl/mvelim_unit.sv
module mvelim_unit
   import mvelim_pkg::*;
#(
   parameter int NUM_AREGS = 32,
   parameter int NUM_FILES = 4,
   parameter int QUOTA_W   = 3,
   parameter int LANES     = 2,
   parameter int AREG_W    = $clog2(NUM_AREGS),
   parameter int FILE_W    = $clog2(NUM_FILES)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_FILES-1:0][QUOTA_W-1:0] cfg_quota,
   input  logic [NUM_FILES-1:0]           cfg_zero_only,
   input  logic [LANES-1:0]               mv_valid,
   input  logic [LANES-1:0][AREG_W-1:0]   mv_src,
   input  logic [LANES-1:0][AREG_W-1:0]   mv_dst,
   input  logic [LANES-1:0][FILE_W-1:0]   mv_src_file,
   input  logic [LANES-1:0][FILE_W-1:0]   mv_dst_file,
   input  logic [LANES-1:0]               mv_dst_nested,
   input  logic [LANES-1:0]               mv_parent_ok,
   input  logic [LANES-1:0]               mv_clears_upper,
   input  logic [LANES-1:0]               mv_src_has_root,
   input  logic [LANES-1:0][AREG_W-1:0]   mv_src_root,
   input  logic [LANES-1:0]               mv_root_alias_vld,
   input  logic [LANES-1:0][AREG_W-1:0]   mv_root_alias,
   input  logic                           wr_valid,
   input  logic [AREG_W-1:0]              wr_reg,
   input  logic [NUM_AREGS-1:0]           wr_sub_mask,
   input  logic [NUM_AREGS-1:0]           wr_parent_mask,
   input  logic                           wr_clears_upper,
   input  logic                           wr_zero,
   input  logic                           wr_elim,
   output logic [LANES-1:0]               mv_grant,
   output logic [LANES-1:0]               mv_zero,
   output logic [LANES-1:0]               alias_we,
   output logic [LANES-1:0][AREG_W-1:0]   alias_dst,
   output logic [LANES-1:0][AREG_W-1:0]   alias_tgt,
   output logic [NUM_AREGS-1:0]           zero_vec
);

   localparam int CNT_W = $clog2(LANES + 1);

   // elaboration-time parameter checks
   if (NUM_AREGS < 2 || NUM_AREGS != (1 << AREG_W)) begin : g_bad_aregs
      $error("NUM_AREGS must be a power of two of at least 2");
   end
   if (NUM_FILES < 2 || NUM_FILES != (1 << FILE_W)) begin : g_bad_files
      $error("NUM_FILES must be a power of two of at least 2");
   end
   if (LANES < 1 || QUOTA_W < 1) begin : g_bad_lanes
      $error("LANES and QUOTA_W must be positive");
   end

   mvelim_zero_track #(.NUM_AREGS(NUM_AREGS), .AREG_W(AREG_W)) u_zero (
      .clk             (clk),
      .rst_n           (rst_n),
      .wr_valid        (wr_valid),
      .wr_reg          (wr_reg),
      .wr_sub_mask     (wr_sub_mask),
      .wr_parent_mask  (wr_parent_mask),
      .wr_clears_upper (wr_clears_upper),
      .wr_zero         (wr_zero),
      .wr_elim         (wr_elim),
      .zero_q          (zero_vec)
   );

   logic lane_grant [LANES];

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [CNT_W-1:0] used;
      logic             src_zero;
      refuse_rsn_e      rsn;

      // grants of earlier lanes in the same destination file
      if (i == 0) begin : g_first
         assign used = '0;
      end else begin : g_later
         always_comb begin
            used = '0;
            for (int j = 0; j < i; j++)
               if (lane_grant[j] && (mv_dst_file[j] == mv_dst_file[i]))
                  used = used + CNT_W'(1);
         end
      end

      assign src_zero = zero_vec[mv_src[i]];

      mvelim_lane_gate #(.FILE_W(FILE_W), .QUOTA_W(QUOTA_W), .CNT_W(CNT_W)) u_gate (
         .valid        (mv_valid[i]),
         .src_file     (mv_src_file[i]),
         .dst_file     (mv_dst_file[i]),
         .dst_nested   (mv_dst_nested[i]),
         .parent_ok    (mv_parent_ok[i]),
         .clears_upper (mv_clears_upper[i]),
         .quota        (cfg_quota[mv_dst_file[i]]),
         .zero_only    (cfg_zero_only[mv_dst_file[i]]),
         .src_zero     (src_zero),
         .used         (used),
         .grant        (lane_grant[i]),
         .rsn          (rsn)
      );

      mvelim_alias_pick #(.AREG_W(AREG_W)) u_alias (
         .grant          (lane_grant[i]),
         .src            (mv_src[i]),
         .dst            (mv_dst[i]),
         .has_root       (mv_src_has_root[i]),
         .root           (mv_src_root[i]),
         .root_alias_vld (mv_root_alias_vld[i]),
         .root_alias     (mv_root_alias[i]),
         .we             (alias_we[i]),
         .tgt            (alias_tgt[i])
      );

      assign mv_grant[i]  = lane_grant[i];
      assign mv_zero[i]   = lane_grant[i] && src_zero;
      assign alias_dst[i] = mv_dst[i];

      // R1
      same_file_chk: assert property (@(posedge clk) disable iff (!rst_n)
         mv_grant[i] |-> mv_src_file[i] == mv_dst_file[i]);
      // R4
      zero_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
         mv_grant[i] && cfg_zero_only[mv_dst_file[i]] |-> zero_vec[mv_src[i]]);
      // R5
      nested_chk: assert property (@(posedge clk) disable iff (!rst_n)
         mv_grant[i] && mv_dst_nested[i] |-> mv_parent_ok[i] && mv_clears_upper[i]);
      // R8
      zmove_chk: assert property (@(posedge clk) disable iff (!rst_n)
         mv_zero[i] |-> mv_grant[i] && zero_vec[mv_src[i]]);
      // R9
      alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
         alias_we[i] |-> mv_grant[i] && (alias_tgt[i] != alias_dst[i]));
   end

   for (genvar f = 0; f < NUM_FILES; f++) begin : g_file_chk
      int grants_in_file;
      always_comb begin
         grants_in_file = 0;
         for (int k = 0; k < LANES; k++)
            if (mv_grant[k] && (mv_dst_file[k] == FILE_W'(f)))
               grants_in_file++;
      end
      // R3
      quota_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cfg_quota[f] != '0 |-> grants_in_file <= int'(cfg_quota[f]));
   end

endmodule

// File: tb/mvelim_unit_tb.sv
module mvelim_unit_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NA = 32;
   localparam int NF = 4;
   localparam int QW = 3;
   localparam int LN = 2;
   localparam int AW = 5;
   localparam int FW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NF-1:0][QW-1:0] cfg_quota;
   logic [NF-1:0]         cfg_zero_only;
   logic [LN-1:0]         mv_valid;
   logic [LN-1:0][AW-1:0] mv_src, mv_dst, mv_src_root, mv_root_alias;
   logic [LN-1:0][FW-1:0] mv_src_file, mv_dst_file;
   logic [LN-1:0]         mv_dst_nested, mv_parent_ok, mv_clears_upper;
   logic [LN-1:0]         mv_src_has_root, mv_root_alias_vld;
   logic                  wr_valid, wr_clears_upper, wr_zero, wr_elim;
   logic [AW-1:0]         wr_reg;
   logic [NA-1:0]         wr_sub_mask, wr_parent_mask;
   logic [LN-1:0]         mv_grant, mv_zero, alias_we;
   logic [LN-1:0][AW-1:0] alias_dst, alias_tgt;
   logic [NA-1:0]         zero_vec;

   always #(CLK_PERIOD/2) clk = ~clk;

   mvelim_unit #(.NUM_AREGS(NA), .NUM_FILES(NF), .QUOTA_W(QW), .LANES(LN)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_quota(cfg_quota), .cfg_zero_only(cfg_zero_only),
      .mv_valid(mv_valid), .mv_src(mv_src), .mv_dst(mv_dst),
      .mv_src_file(mv_src_file), .mv_dst_file(mv_dst_file),
      .mv_dst_nested(mv_dst_nested), .mv_parent_ok(mv_parent_ok),
      .mv_clears_upper(mv_clears_upper), .mv_src_has_root(mv_src_has_root),
      .mv_src_root(mv_src_root), .mv_root_alias_vld(mv_root_alias_vld),
      .mv_root_alias(mv_root_alias), .wr_valid(wr_valid), .wr_reg(wr_reg),
      .wr_sub_mask(wr_sub_mask), .wr_parent_mask(wr_parent_mask),
      .wr_clears_upper(wr_clears_upper), .wr_zero(wr_zero), .wr_elim(wr_elim),
      .mv_grant(mv_grant), .mv_zero(mv_zero), .alias_we(alias_we),
      .alias_dst(alias_dst), .alias_tgt(alias_tgt), .zero_vec(zero_vec)
   );

   int checks = 0;
   int errors = 0;
   bit zm [NA];

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // Reference decision for the current inputs, then compare
   task automatic compare(input string tag);
      logic [LN-1:0] eg, ez, ew;
      logic [NA-1:0] ezv;
      for (int i = 0; i < LN; i++) begin
         int used = 0;
         int q;
         int tg;
         bit ok;
         for (int j = 0; j < i; j++)
            if (eg[j] && mv_dst_file[j] == mv_dst_file[i]) used++;
         q  = cfg_quota[mv_dst_file[i]];
         ok = mv_valid[i] && (mv_src_file[i] == mv_dst_file[i]);
         if (mv_dst_nested[i] && !(mv_parent_ok[i] && mv_clears_upper[i])) ok = 0;
         if (q != 0 && used >= q) ok = 0;
         if (cfg_zero_only[mv_dst_file[i]] && !zm[mv_src[i]]) ok = 0;
         eg[i] = ok;
         ez[i] = ok && zm[mv_src[i]];
         tg = mv_src_has_root[i] ? mv_src_root[i] : mv_src[i];
         if (mv_root_alias_vld[i]) tg = mv_root_alias[i];
         ew[i] = ok && (tg != mv_dst[i]);
         if (ew[i]) chk(tag, "alias_tgt", alias_tgt[i], tg);
      end
      for (int k = 0; k < NA; k++) ezv[k] = zm[k];
      chk(tag, "grant", mv_grant, eg);
      chk(tag, "zero_move", mv_zero, ez);
      chk(tag, "alias_we", alias_we, ew);
      chk(tag, "zero_vec", zero_vec, ezv);
   endtask

   task automatic model_write();
      if (!wr_valid) return;
      for (int k = 0; k < NA; k++) begin
         bit hit = (k == wr_reg) || wr_sub_mask[k] || (wr_clears_upper && wr_parent_mask[k]);
         if (hit) begin
            if (wr_zero) zm[k] = 1;
            else if (!wr_elim) zm[k] = 0;
         end
      end
   endtask

   // inputs are set at the falling edge; compare, then advance one cycle
   task automatic cyc(input string tag);
      #2 compare(tag);
      @(posedge clk);
      model_write();
      @(negedge clk);
   endtask

   task automatic idle();
      mv_valid = '0; mv_dst_nested = '0; mv_parent_ok = '0; mv_clears_upper = '0;
      mv_src_has_root = '0; mv_root_alias_vld = '0; mv_src_root = '0; mv_root_alias = '0;
      mv_src_file = '0; mv_dst_file = '0; mv_src = '0; mv_dst = '0;
      wr_valid = 0; wr_reg = '0; wr_sub_mask = '0; wr_parent_mask = '0;
      wr_clears_upper = 0; wr_zero = 0; wr_elim = 0;
   endtask

   task automatic lane(input int i, input int s, input int d, input int sf, input int df);
      mv_valid[i] = 1; mv_src[i] = AW'(s); mv_dst[i] = AW'(d);
      mv_src_file[i] = FW'(sf); mv_dst_file[i] = FW'(df);
   endtask

   task automatic wr(input int r, input bit z, input bit el, input bit cu,
                     input logic [NA-1:0] sub, input logic [NA-1:0] par);
      wr_valid = 1; wr_reg = AW'(r); wr_zero = z; wr_elim = el;
      wr_clears_upper = cu; wr_sub_mask = sub; wr_parent_mask = par;
   endtask

   bit done = 0;

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < NA; k++) zm[k] = 0;
      cfg_quota = '0; cfg_zero_only = '0;
      idle();
      repeat (3) @(negedge clk);
      chk("R10", "zero_vec in reset", zero_vec, '0);
      rst_n = 1;
      cyc("R10");

      // R1: differing files refused, matching files granted
      idle(); lane(0, 1, 2, 0, 1); lane(1, 3, 4, 2, 2); cyc("R1");

      // R2: unlimited quota, both lanes of file 1 granted
      idle(); lane(0, 1, 2, 1, 1); lane(1, 3, 4, 1, 1); cyc("R2");

      // R3: quota 1, second lane of same file refused; fresh next cycle (R2)
      cfg_quota[1] = 3'd1;
      idle(); lane(0, 1, 2, 1, 1); lane(1, 3, 4, 1, 1); cyc("R3");
      idle(); lane(0, 5, 6, 2, 2); lane(1, 3, 4, 1, 1); cyc("R2");
      idle(); lane(0, 1, 2, 1, 1); lane(1, 3, 4, 3, 3); cyc("R3");
      cfg_quota[1] = 3'd0;

      // R6 / R4 / R8: zero-only mode follows zero writes
      cfg_zero_only[2] = 1;
      idle(); lane(0, 7, 8, 2, 2); cyc("R4");
      idle(); wr(7, 1, 0, 0, 32'h0000_0000, 32'h0000_0200); cyc("R6");
      idle(); lane(0, 7, 8, 2, 2); lane(1, 10, 11, 2, 2); cyc("R8");
      chk("R6", "parent bit without clears_upper", zero_vec[9], 1'b0);

      // R6: parent bits set when clears_upper, sub-register bits too
      idle(); wr(12, 1, 0, 1, 32'h0000_2000, 32'h0000_4000); cyc("R6");
      chk("R6", "parent bit with clears_upper", zero_vec[14], 1'b1);

      // R7: eliminated non-zero write keeps bits, normal write clears
      idle(); wr(12, 0, 1, 1, 32'h0000_2000, 32'h0000_4000); cyc("R7");
      chk("R7", "elim write keeps", zero_vec[13:12], 2'b11);
      idle(); wr(12, 0, 0, 1, 32'h0000_2000, 32'h0000_4000); cyc("R7");
      chk("R7", "plain write clears", zero_vec[14:12], 3'b000);
      cfg_zero_only[2] = 0;

      // R5: nested destination rules
      idle(); lane(0, 1, 2, 0, 0); mv_dst_nested[0] = 1; cyc("R5");
      mv_parent_ok[0] = 1; cyc("R5");
      mv_clears_upper[0] = 1; cyc("R5");
      mv_parent_ok[0] = 0; cyc("R5");

      // R9: alias target choice and suppression
      idle(); lane(0, 3, 9, 0, 0); cyc("R9");
      mv_src_has_root[0] = 1; mv_src_root[0] = AW'(20); cyc("R9");
      mv_root_alias_vld[0] = 1; mv_root_alias[0] = AW'(25); cyc("R9");
      mv_root_alias[0] = AW'(9); cyc("R9");
      idle(); lane(0, 9, 9, 0, 0); lane(1, 4, 5, 0, 0); cyc("R9");

      // mixed random traffic against the model
      for (int n = 0; n < 400; n++) begin
         idle();
         for (int f = 0; f < NF; f++) begin
            cfg_quota[f] = QW'($urandom_range(0, 2));
            cfg_zero_only[f] = ($urandom_range(0, 3) == 0);
         end
         for (int i = 0; i < LN; i++) begin
            mv_valid[i] = $urandom_range(0, 4) != 0;
            mv_src[i] = AW'($urandom_range(0, 7));
            mv_dst[i] = AW'($urandom_range(0, 7));
            mv_dst_file[i] = FW'($urandom_range(0, 1));
            mv_src_file[i] = ($urandom_range(0, 5) == 0) ? FW'(2) : mv_dst_file[i];
            mv_dst_nested[i] = $urandom_range(0, 1);
            mv_parent_ok[i] = $urandom_range(0, 3) != 0;
            mv_clears_upper[i] = $urandom_range(0, 3) != 0;
            mv_src_has_root[i] = $urandom_range(0, 1);
            mv_src_root[i] = AW'($urandom_range(0, 7));
            mv_root_alias_vld[i] = $urandom_range(0, 1);
            mv_root_alias[i] = AW'($urandom_range(0, 7));
         end
         if ($urandom_range(0, 1) == 1)
            wr($urandom_range(0, 7), $urandom_range(0, 1), $urandom_range(0, 1),
               $urandom_range(0, 1), NA'($urandom_range(0, 255)), NA'($urandom_range(0, 255)));
         cyc("R3");
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule